// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Host Controller

This block is the master side of a three-wire serial EEPROM link with 16-bit words and 6-bit addresses. A client hands it one command at a time through a valid/ready request port: a 3-bit operation code, an address and a data word. The controller turns the request into one or more serial frames. It drives chip select, the serial clock and the host-to-device data line, and it receives the device's data line. Every timing figure is a whole number of system clock cycles.

A request can need more than one frame. The first programming request after reset, and the first one after a lock request, is preceded by an unlock frame. A write-all request is preceded by an erase-all frame. After every programming frame, chip select drops for the minimum low time and rises again. The controller then watches the device's status level until it reads ready. A single-cycle done pulse closes each request. It carries read data and an error flag, which is raised when status polling runs out of time.

Top module: `mw_eeprom_host`

## Requirements
- R1: `req_ready_o` is high only while the controller is idle with chip select low. A request is taken on a cycle where both valid and ready are high. Every taken request ends with exactly one single-cycle `rsp_done_o` pulse. Operation codes are: 0 read, 1 write, 2 erase, 3 erase-all, 4 write-all, 5 lock.
- R2: Each frame starts with a 1 sent while chip select is high. Two opcode bits follow, then six address bits, all most significant bit first. The opcodes are: read 10, write 01, erase 11, and 00 for the address-free commands. For those commands the top two address bits select the command: 11 unlock, 00 lock, 10 erase-all, 01 write-all. The remaining address bits are 0.
- R3: Write and write-all frames append 16 data bits, most significant bit first, for 25 clock pulses in total. Erase, erase-all, unlock and lock frames are 9 clock pulses long.
- R4: A read frame has 25 clock pulses. The device bit seen in the pulse that carries the last address bit is a dummy and is discarded. The next 16 bits form `rsp_rdata_o`, most significant bit first. The result is valid with `rsp_done_o`.
- R5: The serial clock is high only while chip select is high. Each high phase lasts `HI_CYC` cycles and each low phase inside a frame lasts `LO_CYC` cycles. `do_o` changes only on a cycle where the serial clock is low both before and after the change.
- R6: Before every rise of chip select, chip select has been low for at least `CSL_CYC` cycles. This includes the rise that starts status polling.
- R7: After a programming frame, the controller drops chip select, raises it again and samples `di_i` each cycle. It completes the frame only after it has read a 1 (ready).
- R8: After reset, and after a lock request, the next programming request is preceded automatically by one unlock frame. No programming frame reaches a locked device.
- R9: A write-all request is preceded automatically by an erase-all frame. All words then hold the write-all data.
- R10: If ready is not seen within `POLL_MAX` polling cycles, the request ends with `rsp_done_o` and `rsp_err_o` high together. Any frames of that request not yet sent are dropped. `rsp_err_o` is never high without `rsp_done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Controller idle, request can be taken |
| req_op_i | input | 3 | Operation code (R1) |
| req_addr_i | input | 6 | Word address |
| req_wdata_i | input | 16 | Data for write and write-all |
| rsp_done_o | output | 1 | Single-cycle completion pulse |
| rsp_rdata_o | output | 16 | Read result, valid with done after a read |
| rsp_err_o | output | 1 | Ready-poll timeout, high with done |
| cs_o | output | 1 | Chip select to the device |
| sk_o | output | 1 | Serial clock to the device |
| do_o | output | 1 | Serial data to the device |
| di_i | input | 1 | Serial data and ready/busy status from the device |

## Verification
The assertions check the line discipline on every cycle. They cover the serial clock staying low outside chip select and `do_o` moving only while the clock is low. They also cover the chip-select low time before every rise, the single-cycle done pulse, ready appearing only when the bus is idle, and the error flag appearing only with done. The bench scenarios cover what depends on a device actually answering. These are the frame contents and lengths, the dummy bit being skipped on reads, the automatic unlock and erase-all frames, a write landing only after status polling shows ready, and the timeout path. The bench checks them with a behavioural device model and a full 64-word write-then-read sweep.

// File: rtl/mw_pkg.sv
package mw_pkg;
  localparam int unsigned MW_AW  = 6;
  localparam int unsigned MW_DW  = 16;
  localparam int unsigned MW_HW  = 3 + MW_AW;      // start + 2 opcode + address
  localparam int unsigned MW_SRW = MW_HW + MW_DW;  // longest frame

  typedef enum logic [2:0] {
    OP_READ   = 3'd0,
    OP_WRITE  = 3'd1,
    OP_ERASE  = 3'd2,
    OP_ERAL   = 3'd3,
    OP_WRAL   = 3'd4,
    OP_LOCK   = 3'd5,
    OP_UNLOCK = 3'd6
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_GAP, ST_SHIFT, ST_PGAP, ST_POLL
  } st_e;

  function automatic logic is_prog(op_e f);
    return (f == OP_WRITE) || (f == OP_ERASE) || (f == OP_ERAL) || (f == OP_WRAL);
  endfunction

  function automatic logic has_data(op_e f);
    return (f == OP_WRITE) || (f == OP_WRAL);
  endfunction

  function automatic logic [MW_HW-1:0] frame_hdr(op_e f, logic [MW_AW-1:0] a);
    logic [MW_AW-3:0] z;
    z = '0;
    unique case (f)
      OP_WRITE:  return {3'b101, a};
      OP_ERASE:  return {3'b111, a};
      OP_ERAL:   return {3'b100, 2'b10, z};
      OP_WRAL:   return {3'b100, 2'b01, z};
      OP_LOCK:   return {3'b100, 2'b00, z};
      OP_UNLOCK: return {3'b100, 2'b11, z};
      default:   return {3'b110, a};
    endcase
  endfunction
endpackage

// File: rtl/mw_sclk_gen.sv
module mw_sclk_gen #(
  parameter int unsigned LO_CYC = 2,
  parameter int unsigned HI_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic sk_o,
  output logic set_o,   // first low cycle of a slot: update data
  output logic smp_o    // last high cycle of a slot: sample, advance
);
  localparam int unsigned MAXP = (LO_CYC > HI_CYC) ? LO_CYC : HI_CYC;
  localparam int unsigned CW   = $clog2(MAXP + 1);

  logic [CW-1:0] cnt_q;
  logic          hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      hi_q  <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      hi_q  <= 1'b0;
    end else if (!hi_q) begin
      if (cnt_q == CW'(LO_CYC - 1)) begin
        cnt_q <= '0;
        hi_q  <= 1'b1;
      end else cnt_q <= cnt_q + 1'b1;
    end else begin
      if (cnt_q == CW'(HI_CYC - 1)) begin
        cnt_q <= '0;
        hi_q  <= 1'b0;
      end else cnt_q <= cnt_q + 1'b1;
    end
  end

  assign sk_o  = hi_q;
  assign set_o = run_i && !hi_q && (cnt_q == '0);
  assign smp_o = run_i && hi_q && (cnt_q == CW'(HI_CYC - 1));
endmodule

// File: rtl/mw_poll_timer.sv
module mw_poll_timer #(
  parameter int unsigned LIMIT = 100000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic expired_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (!run_i)                      cnt_q <= '0;
    else if (cnt_q != CW'(LIMIT - 1))     cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = run_i && (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/mw_eeprom_host.sv
module mw_eeprom_host
  import mw_pkg::*;
#(
  parameter int unsigned LO_CYC   = 2,
  parameter int unsigned HI_CYC   = 2,
  parameter int unsigned CSL_CYC  = 4,
  parameter int unsigned POLL_MAX = 100000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [2:0]        req_op_i,
  input  logic [MW_AW-1:0]  req_addr_i,
  input  logic [MW_DW-1:0]  req_wdata_i,
  output logic              rsp_done_o,
  output logic [MW_DW-1:0]  rsp_rdata_o,
  output logic              rsp_err_o,
  output logic              cs_o,
  output logic              sk_o,
  output logic              do_o,
  input  logic              di_i
);
  localparam int unsigned GW = $clog2(CSL_CYC + 1);
  localparam int unsigned BW = $clog2(MW_SRW + 1);

  st_e               st_q;
  op_e               op_q, cur_q, nxt_f;
  logic [MW_AW-1:0]  addr_q;
  logic [MW_DW-1:0]  wdata_q, rdata_q;
  logic [MW_SRW-1:0] sreg_q;
  logic [BW-1:0]     bit_q, last_bit;
  logic [GW-1:0]     gap_q;
  logic              wen_q, eral_q, do_q, done_q, err_q;
  logic              set_t, smp_t, tmo, fin;

  mw_sclk_gen #(.LO_CYC(LO_CYC), .HI_CYC(HI_CYC)) i_sclk (
    .clk_i (clk_i), .rst_ni (rst_ni), .run_i (st_q == ST_SHIFT),
    .sk_o  (sk_o),  .set_o  (set_t),  .smp_o (smp_t)
  );

  mw_poll_timer #(.LIMIT(POLL_MAX)) i_tmo (
    .clk_i (clk_i), .rst_ni (rst_ni), .run_i (st_q == ST_POLL), .expired_o (tmo)
  );

  // Frame to send next for the pending request
  always_comb begin
    if (is_prog(op_q) && !wen_q)          nxt_f = OP_UNLOCK;
    else if (op_q == OP_WRAL && !eral_q)  nxt_f = OP_ERAL;
    else                                  nxt_f = op_q;
  end

  assign last_bit = (has_data(cur_q) || cur_q == OP_READ) ? BW'(MW_SRW - 1) : BW'(MW_HW - 1);

  always_comb begin
    fin = 1'b0;
    if (st_q == ST_SHIFT && smp_t && bit_q == last_bit && !is_prog(cur_q)) fin = 1'b1;
    if (st_q == ST_POLL && di_i) fin = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      op_q    <= OP_READ;
      cur_q   <= OP_READ;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      sreg_q  <= '0;
      bit_q   <= '0;
      gap_q   <= '0;
      wen_q   <= 1'b0;
      eral_q  <= 1'b0;
      do_q    <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (req_valid_i) begin
          op_q    <= op_e'(req_op_i);
          addr_q  <= req_addr_i;
          wdata_q <= req_wdata_i;
          eral_q  <= 1'b0;
          gap_q   <= '0;
          st_q    <= ST_GAP;
        end
        ST_GAP: if (gap_q == GW'(CSL_CYC - 1)) begin
          cur_q  <= nxt_f;
          sreg_q <= {frame_hdr(nxt_f, addr_q), has_data(nxt_f) ? wdata_q : '0};
          bit_q  <= '0;
          st_q   <= ST_SHIFT;
        end else gap_q <= gap_q + 1'b1;
        ST_SHIFT: begin
          if (set_t) do_q <= sreg_q[MW_SRW-1];
          if (smp_t) begin
            sreg_q <= sreg_q << 1;
            bit_q  <= bit_q + 1'b1;
            if (cur_q == OP_READ && bit_q >= BW'(MW_HW))
              rdata_q <= {rdata_q[MW_DW-2:0], di_i};
            if (bit_q == last_bit && is_prog(cur_q)) begin
              gap_q <= '0;
              st_q  <= ST_PGAP;
            end
          end
        end
        ST_PGAP: if (gap_q == GW'(CSL_CYC - 1)) st_q <= ST_POLL;
                 else gap_q <= gap_q + 1'b1;
        ST_POLL: if (!di_i && tmo) begin
          done_q <= 1'b1;
          err_q  <= 1'b1;
          st_q   <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase

      if (fin) begin
        if (cur_q == OP_UNLOCK) wen_q <= 1'b1;
        if (cur_q == OP_LOCK)   wen_q <= 1'b0;
        if (cur_q == OP_ERAL)   eral_q <= 1'b1;
        if (cur_q == op_q) begin
          done_q <= 1'b1;
          st_q   <= ST_IDLE;
        end else begin
          gap_q <= '0;
          st_q  <= ST_GAP;
        end
      end
    end
  end

  assign req_ready_o = (st_q == ST_IDLE);
  assign cs_o        = (st_q == ST_SHIFT) || (st_q == ST_POLL);
  assign do_o        = do_q;
  assign rsp_done_o  = done_q;
  assign rsp_err_o   = err_q;
  assign rsp_rdata_o = rdata_q;
endmodule

// File: rtl/mw_eeprom_host_chk.sv
module mw_eeprom_host_chk #(
  parameter int unsigned CSL_CYC = 4
) (
  input logic clk_i,
  input logic rst_ni,
  input logic req_ready_o,
  input logic rsp_done_o,
  input logic rsp_err_o,
  input logic cs_o,
  input logic sk_o,
  input logic do_o
);
  logic [15:0] low_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               low_cnt <= '0;
    else if (cs_o)             low_cnt <= '0;
    else if (low_cnt != '1)    low_cnt <= low_cnt + 1'b1;
  end

  assert_sk_within_cs_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sk_o |-> cs_o);

  assert_do_moves_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(do_o) |-> (!sk_o && !$past(sk_o)));

  assert_cs_low_time_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_o) |-> (low_cnt >= 16'(CSL_CYC)));

  assert_ready_bus_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !cs_o);

  assert_done_single_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_done_o |=> !rsp_done_o);

  assert_err_with_done_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_err_o |-> rsp_done_o);
endmodule

bind mw_eeprom_host mw_eeprom_host_chk #(.CSL_CYC(CSL_CYC)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_ready_o (req_ready_o),
  .rsp_done_o  (rsp_done_o),
  .rsp_err_o   (rsp_err_o),
  .cs_o        (cs_o),
  .sk_o        (sk_o),
  .do_o        (do_o)
);

// File: tb/test_mw_eeprom_host.sv
`timescale 1ns/1ps
module test_mw_eeprom_host;
  localparam int LO = 2, HI = 2, CSL = 3, PMAX = 200, BUSY = 40;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_op = '0;
  logic [5:0]  req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ready, rsp_done, rsp_err, cs, sk, mdo, mdi;
  logic [15:0] rsp_rdata;

  always #2 clk = ~clk;

  mw_eeprom_host #(.LO_CYC(LO), .HI_CYC(HI), .CSL_CYC(CSL), .POLL_MAX(PMAX)) i_mw_eeprom_host (
    .clk_i (clk), .rst_ni (rst_n), .req_valid_i (req_valid), .req_ready_o (req_ready),
    .req_op_i (req_op), .req_addr_i (req_addr), .req_wdata_i (req_wdata),
    .rsp_done_o (rsp_done), .rsp_rdata_o (rsp_rdata), .rsp_err_o (rsp_err),
    .cs_o (cs), .sk_o (sk), .do_o (mdo), .di_i (mdi)
  );

  int checks = 0, fails = 0;
  longint cyc = 0, busy_until = 0;
  logic stuck = 1'b0;

  // Behavioural device
  logic [15:0] mem [64];
  logic        dv_st = 1'b0, dv_rd = 1'b0, dv_rbit = 1'b0, dv_wen = 1'b0;
  logic [7:0]  dv_hdr = '0;
  logic [15:0] dv_dat = '0;
  int          dv_n = 0, last_n = -1, n_ewen = 0, n_eral = 0, n_noen = 0;
  wire         busy = (cyc < busy_until);

  assign mdi = dv_rd ? dv_rbit : (!busy && !stuck);

  initial for (int i = 0; i < 64; i++) mem[i] = 16'h0000;

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge sk or negedge cs) begin
    if (!cs) begin
      if (dv_st) last_n = dv_n;
      dv_st = 1'b0;
      dv_rd = 1'b0;
    end else if (!dv_st) begin
      if (mdo) begin dv_st = 1'b1; dv_n = 0; end
    end else begin
      dv_n++;
      if (dv_n <= 8) dv_hdr = {dv_hdr[6:0], mdo};
      else if (dv_n <= 24) dv_dat = {dv_dat[14:0], mdo};
      if (dv_rd && dv_n >= 9 && dv_n <= 24) dv_rbit = mem[dv_hdr[5:0]][24-dv_n];
      if (dv_n == 8) begin
        case (dv_hdr[7:6])
          2'b10: begin dv_rd = 1'b1; dv_rbit = 1'b0; end
          2'b11: if (!dv_wen) n_noen++;
                 else begin mem[dv_hdr[5:0]] = 16'hFFFF; busy_until = cyc + BUSY; end
          2'b00: case (dv_hdr[5:4])
            2'b11: begin dv_wen = 1'b1; n_ewen++; end
            2'b00: dv_wen = 1'b0;
            2'b10: if (!dv_wen) n_noen++;
                   else begin
                     n_eral++;
                     for (int i = 0; i < 64; i++) mem[i] = 16'hFFFF;
                     busy_until = cyc + BUSY;
                   end
            default: ;
          endcase
          default: ;
        endcase
      end
      if (dv_n == 24 && !dv_rd) begin
        if (dv_hdr[7:6] == 2'b01) begin
          if (!dv_wen) n_noen++;
          else begin mem[dv_hdr[5:0]] = dv_dat; busy_until = cyc + BUSY; end
        end else if (dv_hdr[7:4] == 4'b0001) begin
          if (!dv_wen) n_noen++;
          else begin
            for (int i = 0; i < 64; i++) mem[i] = mem[i] & dv_dat;  // no built-in erase
            busy_until = cyc + BUSY;
          end
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Serial clock high phase length, chip select low length
  int hi_len = 0, lo_len = 0;
  always @(negedge clk) if (rst_n) begin
    if (sk) hi_len++;
    else if (hi_len != 0) begin
      chk(hi_len == HI, "R5 sclk high length", hi_len, HI);
      hi_len = 0;
    end
    if (!cs) lo_len++;
    else if (lo_len != 0) begin
      chk(lo_len >= CSL, "R6 cs low length", lo_len, CSL);
      lo_len = 0;
    end
  end

  logic [15:0] rd;
  logic        er;

  task automatic req(input logic [2:0] op, input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = d;
    @(posedge clk);
    while (!req_ready) @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_done) @(negedge clk);
    rd = rsp_rdata;
    er = rsp_err;
    if (op != 3'd0 && op != 3'd5 && !stuck)
      chk(!busy, "R7 done before device ready", busy, 0);
  endtask

  function automatic logic [15:0] pat(int a);
    return 16'((a * 16'h0A31) ^ 16'h5C00);
  endfunction

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) if (cyc > 190000) begin
    checks++; fails++;
    $display("FAIL R1 watchdog: request never completed actual=hang expected=done");
    summary();
  end

  logic [15:0] expm [64];

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1 && cs == 1'b0 && sk == 1'b0 && rsp_done == 1'b0,
        "R1 reset state", {req_ready, cs, sk, rsp_done}, 4'b1000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(req_ready == 1'b1 && cs == 1'b0, "R1 idle after reset", {req_ready, cs}, 2'b10);

    // Write sweep, all addresses
    for (int a = 0; a < 64; a++) begin
      expm[a] = pat(a);
      req(3'd1, 6'(a), pat(a));
      chk(er == 1'b0, "R1 write no error", er, 0);
    end
    chk(last_n == 24, "R3 write frame pulses after start", last_n, 24);
    chk(n_ewen == 1, "R8 single unlock before writes", n_ewen, 1);
    chk(n_noen == 0, "R8 no program while locked", n_noen, 0);

    // Read sweep
    for (int a = 0; a < 64; a++) begin
      req(3'd0, 6'(a), 16'h0000);
      chk(rd == expm[a] && !er, "R2/R4 read back", rd, expm[a]);
    end
    chk(last_n == 24, "R4 read frame pulses after start", last_n, 24);

    // Erase one word
    req(3'd2, 6'd9, 16'h0000);
    chk(last_n == 8, "R3 erase frame pulses after start", last_n, 8);
    expm[9] = 16'hFFFF;
    req(3'd0, 6'd9, 16'h0000);
    chk(rd == 16'hFFFF, "R3 erased word", rd, 16'hFFFF);
    req(3'd0, 6'd8, 16'h0000);
    chk(rd == expm[8], "R2 neighbour untouched", rd, expm[8]);

    // Lock, then a write must re-unlock
    req(3'd5, 6'd0, 16'h0000);
    chk(last_n == 8, "R3 lock frame pulses", last_n, 8);
    req(3'd1, 6'd3, 16'hBEEF);
    chk(n_ewen == 2, "R8 unlock after lock", n_ewen, 2);
    req(3'd0, 6'd3, 16'h0000);
    chk(rd == 16'hBEEF, "R8 write after relock", rd, 16'hBEEF);

    // Write-all over mixed data
    req(3'd4, 6'd0, 16'h1234);
    chk(n_eral == 1, "R9 erase-all inserted", n_eral, 1);
    for (int a = 0; a < 64; a++) begin
      req(3'd0, 6'(a), 16'h0000);
      chk(rd == 16'h1234, "R9 write-all word", rd, 16'h1234);
    end

    // Plain erase-all
    req(3'd3, 6'd0, 16'h0000);
    chk(n_eral == 2, "R3 erase-all request", n_eral, 2);
    req(3'd0, 6'd63, 16'h0000);
    chk(rd == 16'hFFFF, "R3 erase-all word", rd, 16'hFFFF);

    // Poll timeout
    stuck = 1'b1;
    req(3'd1, 6'd1, 16'h0F0F);
    chk(er == 1'b1, "R10 timeout error", er, 1);
    stuck = 1'b0;
    req(3'd0, 6'd1, 16'h0000);
    chk(er == 1'b0 && rd == 16'h0F0F, "R10 recovery read", rd, 16'h0F0F);
    chk(n_noen == 0, "R8 no locked program at end", n_noen, 0);

    summary();
  end
endmodule